// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns a single-beat write request from synchronous logic into one write cycle on an asynchronous static RAM that has a 16-bit data bus and separate upper-byte and lower-byte enables. A request carries an address, a data word and a two-bit byte mask. It is accepted through a ready/valid handshake. The block then drives the active-low chip enable, write enable and byte enables, the address and the data bus in a fixed order, and raises a one-cycle done pulse when the memory is released.

Each timing minimum of the memory is a nanosecond parameter. The block converts it at elaboration into a whole number of system clock cycles, rounded up, with at least one cycle. The write window is the time during which chip enable, at least one byte enable and write enable are all low. The block always closes that window by raising write enable first, so every setup and hold rule refers to one edge. Chip enable and the byte enables stay low for a hold interval after that edge. The data driver turns on one clock after write enable falls and turns off one clock after it rises, which keeps it clear of the memory's own output turn-off and turn-on window. A new request stays blocked until the whole write cycle time has run out.

With the default parameters (5 ns clock, fastest-grade minimums, 40 ns cycle time) the cycle counts are: setup 1, write-enable low 2, hold 1, and cycle time 8.

Top module: `sram_wr_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, chip enable, write enable and both byte enables are high, the data-bus enable and done are low, and req_ready is high.
- R2: A request is accepted on a rising clock edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the cycle time has expired. Requests presented while req_ready is low have no effect on the address, data or strobes.
- R3: Chip enable goes low in the cycle that follows acceptance. Byte enable bit 1 (upper byte) goes low only if mask bit 1 is set, and bit 0 (lower byte) only if mask bit 0 is set. A mask of 00 runs the cycle with both byte enables high.
- R4: Write enable falls N_AS cycles after chip enable falls, with N_AS = max(1, ceil(T_AS_NS / CLK_NS)).
- R5: Write enable stays low for exactly N_WP cycles. N_WP is the largest of: ceil(T_PWE/CLK); ceil(T_AW/CLK) - N_AS; ceil(T_SCE/CLK) - N_AS; ceil(T_PWB/CLK) - N_AS; and 1 + ceil(T_SD/CLK). Each ceiling has a floor of one.
- R6: The write ends with write enable rising while chip enable and the enabled byte lanes stay low for N_AH = max(1, ceil(T_AH_NS / CLK_NS)) more cycles. The address stays at the accepted value from acceptance through the cycle in which chip enable returns high.
- R7: sram_dq_oe rises one clock after write enable falls and falls one clock after write enable rises. While it is high, sram_dq_o equals the accepted data.
- R8: done is high for exactly one cycle, the cycle in which chip enable returns high.
- R9: req_ready returns high T = max(N_AS + N_WP + N_AH, ceil(T_WC_NS / CLK_NS)) cycles after acceptance. Back-to-back accepted requests are therefore T + 1 cycles apart.
- R10: For every accepted request, at the rising edge of write enable the address, the data, the byte-enable pattern and the chip enable on the memory side match that request, in the order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Write data of the request |
| req_mask | input | DATA_W/8 | Byte mask, bit 1 upper byte, bit 0 lower byte, 1 = write |
| done | output | 1 | One-cycle pulse when the memory is released |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | DATA_W/8 | Byte enables, active low, bit 1 upper |
| sram_dq_o | output | DATA_W | Data to drive onto the memory bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
On every cycle, the assertions check the ordering relations among the strobes: write enable is low only inside chip enable, and byte enables are low only inside chip enable. They also check that write enable rises before chip enable, that the low pulse of write enable has the derived width, that the data driver lags both edges of write enable by one clock with stable data, that address is stable during the cycle, and that done and chip-enable falls follow a handshake. Only the bench scenarios can show the absolute cycle positions measured from acceptance. They also show that each byte mask (including 00) maps onto the correct lanes, that a request held while busy is ignored and then taken T + 1 cycles after the first, and that each write carries the address and data of its own request.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_WRITE,
    PH_HOLD,
    PH_TAIL
  } phase_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // subtraction clamped at zero
  function automatic int unsigned usub(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_AS   = 1,
  parameter int unsigned N_WP   = 2,
  parameter int unsigned N_AH   = 1,
  parameter int unsigned N_TAIL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             timer_zero,
  output phase_t           phase_q,
  output phase_t           phase_nxt,
  output logic             accept,
  output logic             hold_end,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val
);

  phase_t           after_hold_ph;
  logic [CNT_W-1:0] after_hold_val;

  // the stretch that pads out the cycle time exists only when it is needed
  generate
    if (N_TAIL > 0) begin : g_tail
      assign after_hold_ph  = PH_TAIL;
      assign after_hold_val = CNT_W'(N_TAIL - 1);
    end else begin : g_no_tail
      assign after_hold_ph  = PH_IDLE;
      assign after_hold_val = '0;
    end
  endgenerate

  always_comb begin
    phase_nxt  = phase_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_nxt  = PH_SETUP;
          timer_load = 1'b1;
          timer_val  = CNT_W'(N_AS - 1);
        end
      end
      PH_SETUP: begin
        if (timer_zero) begin
          phase_nxt  = PH_WRITE;
          timer_load = 1'b1;
          timer_val  = CNT_W'(N_WP - 1);
        end
      end
      PH_WRITE: begin
        if (timer_zero) begin
          phase_nxt  = PH_HOLD;
          timer_load = 1'b1;
          timer_val  = CNT_W'(N_AH - 1);
        end
      end
      PH_HOLD: begin
        if (timer_zero) begin
          phase_nxt  = after_hold_ph;
          timer_load = 1'b1;
          timer_val  = after_hold_val;
        end
      end
      PH_TAIL: begin
        if (timer_zero) begin
          phase_nxt = PH_IDLE;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_nxt;
    end
  end

  assign accept   = (phase_q == PH_IDLE) && req_valid;
  assign hold_end = (phase_q == PH_HOLD) && timer_zero;

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_q,
  input  phase_t            phase_nxt,
  input  logic              accept,
  input  logic              hold_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BE_W-1:0]   req_mask,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic [BE_W-1:0]   sram_be_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  output logic              done,
  output logic              ready
);

  logic            active_nxt;
  logic [BE_W-1:0] mask_q;
  logic [BE_W-1:0] mask_use;

  assign active_nxt = (phase_nxt == PH_SETUP) || (phase_nxt == PH_WRITE) ||
                      (phase_nxt == PH_HOLD);
  assign mask_use   = accept ? req_mask : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      mask_q     <= '0;
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      done       <= 1'b0;
      ready      <= 1'b1;
    end else begin
      if (accept) begin
        sram_addr <= req_addr;
        sram_dq_o <= req_data;
        mask_q    <= req_mask;
      end
      sram_ce_n  <= !active_nxt;
      sram_we_n  <= (phase_nxt != PH_WRITE);
      // lags write enable by one clock on both edges
      sram_dq_oe <= (phase_q == PH_WRITE);
      done       <= hold_end;
      ready      <= (phase_nxt == PH_IDLE);
    end
  end

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    logic lane_n;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_n <= 1'b1;
      end else begin
        lane_n <= !(active_nxt && mask_use[i]);
      end
    end
    assign sram_be_n[i] = lane_n;
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_AW_NS   = 9,
  parameter int unsigned T_SCE_NS  = 9,
  parameter int unsigned T_PWB_NS  = 9,
  parameter int unsigned T_PWE_NS  = 7,
  parameter int unsigned T_SD_NS   = 5,
  parameter int unsigned T_AH_NS   = 1,
  parameter int unsigned T_WC_NS   = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic                   done,
  output logic [ADDR_W-1:0]      sram_addr,
  output logic                   sram_ce_n,
  output logic                   sram_we_n,
  output logic [DATA_W/8-1:0]    sram_be_n,
  output logic [DATA_W-1:0]      sram_dq_o,
  output logic                   sram_dq_oe
);

  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned N_AS    = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned N_WP    = umax(
      umax(ns_to_cyc(T_PWE_NS, CLK_NS), usub(ns_to_cyc(T_AW_NS, CLK_NS), N_AS)),
      umax(umax(usub(ns_to_cyc(T_SCE_NS, CLK_NS), N_AS),
                usub(ns_to_cyc(T_PWB_NS, CLK_NS), N_AS)),
           1 + ns_to_cyc(T_SD_NS, CLK_NS)));
  localparam int unsigned N_AH    = ns_to_cyc(T_AH_NS, CLK_NS);
  localparam int unsigned N_SUM   = N_AS + N_WP + N_AH;
  localparam int unsigned N_WC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_TAIL  = usub(N_WC, N_SUM);
  localparam int unsigned CNT_MAX = umax(umax(N_AS, N_WP), umax(N_AH, N_TAIL));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  phase_t           phase_q;
  phase_t           phase_nxt;
  logic             accept;
  logic             hold_end;
  logic             timer_load;
  logic             timer_zero;
  logic [CNT_W-1:0] timer_val;

  sram_wr_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (timer_zero)
  );

  sram_wr_fsm #(
    .CNT_W  (CNT_W),
    .N_AS   (N_AS),
    .N_WP   (N_WP),
    .N_AH   (N_AH),
    .N_TAIL (N_TAIL)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .timer_zero (timer_zero),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .hold_end   (hold_end),
    .timer_load (timer_load),
    .timer_val  (timer_val)
  );

  sram_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .phase_q    (phase_q),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .hold_end   (hold_end),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_mask   (req_mask),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_be_n  (sram_be_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe),
    .done       (done),
    .ready      (req_ready)
  );

endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2,
  parameter int unsigned N_WP   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic [BE_W-1:0]   sram_be_n,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe
);

  logic [7:0] we_len;

  always_ff @(posedge clk) begin
    if (rst || sram_we_n) begin
      we_len <= '0;
    end else begin
      we_len <= we_len + 1'b1;
    end
  end

  // R3
  be_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
    sram_ce_n |-> (sram_be_n == {BE_W{1'b1}}));

  // R6
  we_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);

  // R6
  we_ends_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> !sram_ce_n);

  // R4
  we_after_ce_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> $past(!sram_ce_n));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (we_len == 8'(N_WP)));

  // R7
  oe_on_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |=> sram_dq_oe);

  // R7
  oe_off_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |=> !sram_dq_oe);

  // R7
  oe_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> !sram_ce_n);

  // R7
  dq_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R8
  done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (sram_ce_n && $past(!sram_ce_n)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  ce_needs_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_ce_n) |-> $past(req_valid && req_ready));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_wr_seq sram_wr_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BE_W   (BE_W),
  .N_WP   (N_WP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_be_n  (sram_be_n),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_wr_seq.sv
module test_sram_wr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 18;
  localparam int DATA_W     = 16;
  localparam int DUT_CLK_NS = 5;
  localparam int NS_AS  = 0;
  localparam int NS_AW  = 9;
  localparam int NS_SCE = 9;
  localparam int NS_PWB = 9;
  localparam int NS_PWE = 7;
  localparam int NS_SD  = 5;
  localparam int NS_AH  = 1;
  localparam int NS_WC  = 40;

  function automatic int up(int ns);
    int c;
    c = ns / DUT_CLK_NS;
    if (c * DUT_CLK_NS < ns) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_AS = up(NS_AS);
  localparam int E_WP = mx(mx(up(NS_PWE), up(NS_AW) - E_AS),
                           mx(mx(up(NS_SCE) - E_AS, up(NS_PWB) - E_AS), 1 + up(NS_SD)));
  localparam int E_AH = up(NS_AH);
  localparam int E_S  = E_AS + E_WP + E_AH;
  localparam int E_T  = mx(E_S, up(NS_WC));

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [1:0]        req_mask = '0;
  logic              done;
  logic [ADDR_W-1:0] sram_addr;
  logic              sram_ce_n;
  logic              sram_we_n;
  logic [1:0]        sram_be_n;
  logic [DATA_W-1:0] sram_dq_o;
  logic              sram_dq_oe;

  sram_wr_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CLK_NS (DUT_CLK_NS),
    .T_AS_NS (NS_AS), .T_AW_NS (NS_AW), .T_SCE_NS (NS_SCE), .T_PWB_NS (NS_PWB),
    .T_PWE_NS (NS_PWE), .T_SD_NS (NS_SD), .T_AH_NS (NS_AH), .T_WC_NS (NS_WC)
  ) i_sram_wr_seq (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_data (req_data), .req_mask (req_mask), .done (done),
    .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_we_n (sram_we_n),
    .sram_be_n (sram_be_n), .sram_dq_o (sram_dq_o), .sram_dq_oe (sram_dq_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [1:0]        mask;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;

  logic              pre_en = 1'b0;
  logic [ADDR_W-1:0] pre_addr;
  logic [DATA_W-1:0] pre_data;
  logic [1:0]        pre_mask;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: queue the expected write, hand the request over, then follow its timeline
  task automatic drive(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [1:0] m);
    bit acc;
    item_t it;
    it.addr = a; it.data = d; it.mask = m;
    exp_q.push_back(it);
    req_valid = 1'b1; req_addr = a; req_data = d; req_mask = m;
    acc = 1'b0;
    while (!acc) begin
      acc = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int k = 0; k <= E_T; k++) begin
      bit ce_low, we_low, oe_on, in_hold;
      ce_low  = (k < E_S);
      we_low  = (k >= E_AS) && (k < E_AS + E_WP);
      oe_on   = (k >= E_AS + 1) && (k <= E_AS + E_WP);
      in_hold = (k >= E_AS + E_WP) && (k < E_S);
      chk(sram_ce_n == !ce_low, in_hold ? "R6" : "R3", "ce_n", sram_ce_n, !ce_low);
      chk(sram_be_n == (ce_low ? ~m : 2'b11), in_hold ? "R6" : "R3", "be_n",
          sram_be_n, ce_low ? ~m : 2'b11);
      chk(sram_we_n == !we_low, (k <= E_AS) ? "R4" : "R5", "we_n", sram_we_n, !we_low);
      chk(sram_dq_oe == oe_on, "R7", "dq_oe", sram_dq_oe, oe_on);
      if (oe_on) chk(sram_dq_o == d, "R7", "dq_o", sram_dq_o, d);
      chk(done == (k == E_S), "R8", "done", done, k == E_S);
      chk(req_ready == (k >= E_T), (k >= E_T) ? "R9" : "R2", "req_ready",
          req_ready, k >= E_T);
      if (k <= E_S) chk(sram_addr == a, "R6", "addr held", sram_addr, a);
      if (k == 0 && pre_en) begin
        // a request presented while busy must be ignored (R2)
        req_valid = 1'b1; req_addr = pre_addr; req_data = pre_data; req_mask = pre_mask;
      end
      if (k < E_T) @(negedge clk);
    end
    pre_en = 1'b0;
  endtask

  // monitor: capture the bus at the last low cycle of write enable, compare on its rise
  logic              was_low = 1'b0;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [1:0]        cap_be;
  logic              cap_ce, cap_oe;

  always @(negedge clk) begin
    if (!rst) begin
      if (was_low && sram_we_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected write", 64'(cap_addr), 64'hffff_ffff);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk({cap_addr, cap_data, cap_be, cap_ce, cap_oe} ==
              {e.addr, e.data, ~e.mask, 1'b0, 1'b1}, "R10", "write contents",
              {cap_addr, cap_data, cap_be, cap_ce, cap_oe},
              {e.addr, e.data, ~e.mask, 1'b0, 1'b1});
        end
      end
      if (!sram_we_n) begin
        cap_addr = sram_addr; cap_data = sram_dq_o; cap_be = sram_be_n;
        cap_ce = sram_ce_n; cap_oe = sram_dq_oe;
      end
      was_low = !sram_we_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog", 64'd20000, 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 while reset is held
    chk(sram_ce_n == 1'b1 && sram_we_n == 1'b1, "R1", "strobes in reset",
        {sram_ce_n, sram_we_n}, 2'b11);
    chk(sram_be_n == 2'b11, "R1", "be_n in reset", sram_be_n, 2'b11);
    chk(sram_dq_oe == 1'b0 && done == 1'b0, "R1", "oe/done in reset",
        {sram_dq_oe, done}, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1'b1);
    chk(sram_ce_n == 1'b1 && sram_we_n == 1'b1 && sram_be_n == 2'b11, "R1",
        "idle strobes", {sram_ce_n, sram_we_n, sram_be_n}, 4'hf);

    drive(18'h0_1234, 16'hbeef, 2'b11);
    drive(18'h3_ffff, 16'h00a5, 2'b10);   // R3 upper lane only
    drive(18'h0_0000, 16'h5a00, 2'b01);   // R3 lower lane only
    drive(18'h2_aaaa, 16'hffff, 2'b00);   // R3 no lane enabled

    // R2: second request waits while busy, then is taken at T + 1
    pre_en = 1'b1; pre_addr = 18'h1_5555; pre_data = 16'h1357; pre_mask = 2'b11;
    drive(18'h0_0f0f, 16'h2468, 2'b11);
    drive(18'h1_5555, 16'h1357, 2'b11);

    for (int i = 0; i < 6; i++) begin
      drive(ADDR_W'($urandom), DATA_W'($urandom), 2'($urandom));
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "all writes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule